// File: doc/BRIEF.md
# Multi-Bank Selectable Clock Divider

This block takes one fast source clock and produces three divided clock banks. Each bank has its own 2-bit ratio code, which picks division by 2, 3, 4 or 6. Every ratio, the odd one included, gives an output that is high for half of its period. Bank 0 drives two true/complement pairs from one shared divider. Banks 1 and 2 each drive one pair. The output stage is modelled at logic level: the true output and its complement.

The source clock comes from a two-level clock mux. When `pll_en` is high, the VCO clock drives the dividers. When it is low, the reference path is used, and `ref_sel` chooses between the oscillator clock (high) and the test clock (low). An asynchronous active-high reset holds all dividers. On release, every bank starts on the same source edge. A bank's first period uses that bank's built-in default ratio. After that, each bank reloads its ratio code only at the end of a period, so a code change never shortens a pulse.

The block is used wherever a small set of related line-rate clocks must be derived from one synthesizer. Software or straps change the ratio codes while the block runs. Source switching is done while reset is held.

Top module: `clk_bank_div`

## Requirements
- R1: Ratio codes per bank: 2'b00 divides by 2, 2'b01 by 3, 2'b10 by 4, 2'b11 by 6. The output period equals the ratio times the source period.
- R2: The output high time is exactly half the output period for every ratio. For divide by 3 this is 1.5 source cycles, so the output uses both source edges. No high or low run lasts more than 3 source cycles.
- R3: With `pll_en` high the source is `vco_clk`. With `pll_en` low the source is `osc_clk` when `ref_sel` is high and `tst_clk` when `ref_sel` is low.
- R4: While `div_rst` is high, every true output is 0 and every complement output is 1. Asserting reset takes effect at once, without waiting for a source edge.
- R5: Each complement output is the bitwise inverse of its true output at all times.
- R6: After `div_rst` falls, all true outputs rise together on the first rising source edge.
- R7: The first period after reset uses the bank's default ratio: divide by 2 for bank 0 and divide by 4 for banks 1 and 2. The ratio code input is first sampled at the end of that period.
- R8: A new ratio code takes effect only at the end of the current period, which is the end of its low phase. The period in progress completes with its old high time and length.
- R9: Both pairs of bank 0 carry identical levels at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| div_rst | input | 1 | Asynchronous active-high divider reset |
| vco_clk | input | 1 | Synthesizer clock |
| osc_clk | input | 1 | Oscillator reference clock |
| tst_clk | input | 1 | Single-ended test reference clock |
| pll_en | input | 1 | 1: VCO clock is the source; 0: reference path is the source |
| ref_sel | input | 1 | Reference pick: 1 oscillator, 0 test clock |
| bank0_code | input | 2 | Ratio code of bank 0 |
| bank1_code | input | 2 | Ratio code of bank 1 |
| bank2_code | input | 2 | Ratio code of bank 2 |
| bank0_p | output | 2 | Bank 0 true outputs (shared divider) |
| bank0_n | output | 2 | Bank 0 complement outputs |
| bank1_p | output | 1 | Bank 1 true output |
| bank1_n | output | 1 | Bank 1 complement output |
| bank2_p | output | 1 | Bank 2 true output |
| bank2_n | output | 1 | Bank 2 complement output |

## Verification
A ratio-code change and the end-of-period reload can fall on the same source edge. The bench provokes this by changing a running bank's code from divide by 6 to divide by 2 in the middle of a high phase. It then times the next falling and rising output edges: the period in progress must keep its 6-cycle length, and the following period must be 2 cycles. A second coincidence occurs at reset release, where the common start edge and the default-ratio first period overlap with a non-default code already applied at the inputs. The bench judges this by sampling all banks after each of the first eight source edges and comparing with levels computed from the default ratio followed by the applied one.

// File: rtl/clk_bank_div_pkg.sv
`timescale 1ns/1ps
package clk_bank_div_pkg;

    localparam int CNT_W = 3;

    typedef logic [1:0] ratio_code_t;

    localparam ratio_code_t CODE_DIV2 = 2'b00;
    localparam ratio_code_t CODE_DIV3 = 2'b01;
    localparam ratio_code_t CODE_DIV4 = 2'b10;
    localparam ratio_code_t CODE_DIV6 = 2'b11;

    typedef struct packed {
        logic              fresh;
        ratio_code_t       code;
        logic [CNT_W-1:0]  cnt;
        logic              lead;
    } div_state_t;

    // Index of the last source cycle of one output period.
    function automatic logic [CNT_W-1:0] last_index(ratio_code_t c);
        case (c)
            CODE_DIV2: return CNT_W'(1);
            CODE_DIV3: return CNT_W'(2);
            CODE_DIV4: return CNT_W'(3);
            default:   return CNT_W'(5);
        endcase
    endfunction

    // Number of whole source cycles the rising-edge flop stays high.
    function automatic logic [CNT_W-1:0] high_slots(ratio_code_t c);
        case (c)
            CODE_DIV2: return CNT_W'(1);
            CODE_DIV3: return CNT_W'(1);
            CODE_DIV4: return CNT_W'(2);
            default:   return CNT_W'(3);
        endcase
    endfunction

endpackage

// File: rtl/clk_bank_div_src.sv
`timescale 1ns/1ps
module clk_bank_div_src (
    input  logic vco_clk,
    input  logic osc_clk,
    input  logic tst_clk,
    input  logic pll_en,
    input  logic ref_sel,
    output logic src_clk
);

    logic ref_clk;

    always_comb begin
        ref_clk = ref_sel ? osc_clk : tst_clk;
        src_clk = pll_en  ? vco_clk : ref_clk;
    end

endmodule

// File: rtl/clk_bank_div_lane.sv
`timescale 1ns/1ps
module clk_bank_div_lane
    import clk_bank_div_pkg::*;
#(
    parameter int          NPAIR    = 1,
    parameter ratio_code_t DEF_CODE = CODE_DIV2
) (
    input  logic              clk,
    input  logic              rst,
    input  ratio_code_t       code_in,
    output logic [NPAIR-1:0]  out_p,
    output logic [NPAIR-1:0]  out_n
);

    div_state_t st_d, st_q;
    logic       trail_d, trail_q;
    logic       wrap;
    logic       lvl;

    // Rising-edge path: period counter, ratio reload at wrap, leading half.
    always_comb begin
        st_d = st_q;
        wrap = (st_q.cnt == last_index(st_q.code));
        if (st_q.fresh) begin
            st_d.fresh = 1'b0;
            st_d.cnt   = '0;
            st_d.lead  = 1'b1;
        end else if (wrap) begin
            st_d.cnt   = '0;
            st_d.code  = code_in;
            st_d.lead  = 1'b1;
        end else begin
            st_d.cnt   = st_q.cnt + CNT_W'(1);
            st_d.lead  = (st_q.cnt + CNT_W'(1)) < high_slots(st_q.code);
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st_q <= '{fresh: 1'b1, code: DEF_CODE, cnt: '0, lead: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    // Falling-edge path: half-cycle extension used only by the odd ratio.
    always_comb begin
        trail_d = st_q.lead && (st_q.code == CODE_DIV3);
    end

    always_ff @(negedge clk or posedge rst) begin
        if (rst) begin
            trail_q <= 1'b0;
        end else begin
            trail_q <= trail_d;
        end
    end

    assign lvl = st_q.lead | trail_q;

    generate
        for (genvar i = 0; i < NPAIR; i++) begin : g_pair
            assign out_p[i] = lvl;
            assign out_n[i] = ~lvl;
        end
    endgenerate

endmodule

// File: rtl/clk_bank_div.sv
`timescale 1ns/1ps
module clk_bank_div
    import clk_bank_div_pkg::*;
#(
    parameter int          BANK0_PAIRS = 2,
    parameter ratio_code_t BANK0_DEF   = CODE_DIV2,
    parameter ratio_code_t BANK1_DEF   = CODE_DIV4,
    parameter ratio_code_t BANK2_DEF   = CODE_DIV4
) (
    input  logic                    div_rst,
    input  logic                    vco_clk,
    input  logic                    osc_clk,
    input  logic                    tst_clk,
    input  logic                    pll_en,
    input  logic                    ref_sel,
    input  logic [1:0]              bank0_code,
    input  logic [1:0]              bank1_code,
    input  logic [1:0]              bank2_code,
    output logic [BANK0_PAIRS-1:0]  bank0_p,
    output logic [BANK0_PAIRS-1:0]  bank0_n,
    output logic                    bank1_p,
    output logic                    bank1_n,
    output logic                    bank2_p,
    output logic                    bank2_n
);

    logic src_clk;

    clk_bank_div_src u_src (
        .vco_clk (vco_clk),
        .osc_clk (osc_clk),
        .tst_clk (tst_clk),
        .pll_en  (pll_en),
        .ref_sel (ref_sel),
        .src_clk (src_clk)
    );

    clk_bank_div_lane #(.NPAIR(BANK0_PAIRS), .DEF_CODE(BANK0_DEF)) u_bank0 (
        .clk     (src_clk),
        .rst     (div_rst),
        .code_in (bank0_code),
        .out_p   (bank0_p),
        .out_n   (bank0_n)
    );

    clk_bank_div_lane #(.NPAIR(1), .DEF_CODE(BANK1_DEF)) u_bank1 (
        .clk     (src_clk),
        .rst     (div_rst),
        .code_in (bank1_code),
        .out_p   (bank1_p),
        .out_n   (bank1_n)
    );

    clk_bank_div_lane #(.NPAIR(1), .DEF_CODE(BANK2_DEF)) u_bank2 (
        .clk     (src_clk),
        .rst     (div_rst),
        .code_in (bank2_code),
        .out_p   (bank2_p),
        .out_n   (bank2_n)
    );

endmodule

// File: rtl/clk_bank_div_chk.sv
`timescale 1ns/1ps
module clk_bank_div_chk (
    input logic       src_clk,
    input logic       div_rst,
    input logic [1:0] bank0_p,
    input logic [1:0] bank0_n,
    input logic       bank1_p,
    input logic       bank1_n,
    input logic       bank2_p,
    input logic       bank2_n
);

    localparam int RUN_W   = 3;
    localparam int RUN_MAX = 3;
    localparam int NMON    = 3;

    logic [NMON-1:0] mon;
    assign mon = {bank2_p, bank1_p, bank0_p[0]};

    generate
        for (genvar i = 0; i < NMON; i++) begin : g_run
            logic [RUN_W-1:0] hi_run, lo_run;

            always_ff @(posedge src_clk or posedge div_rst) begin
                if (div_rst) begin
                    hi_run <= '0;
                    lo_run <= '0;
                end else begin
                    hi_run <= mon[i] ? ((&hi_run) ? hi_run : hi_run + RUN_W'(1)) : '0;
                    lo_run <= mon[i] ? '0 : ((&lo_run) ? lo_run : lo_run + RUN_W'(1));
                end
            end

            assert_high_run_R2: assert property (@(posedge src_clk) disable iff (div_rst)
                hi_run <= RUN_W'(RUN_MAX))
                else $error("high run too long on bank %0d", i);

            assert_low_run_R2: assert property (@(posedge src_clk) disable iff (div_rst)
                lo_run <= RUN_W'(RUN_MAX))
                else $error("low run too long on bank %0d", i);
        end
    endgenerate

    always @(posedge src_clk) begin
        if (div_rst) begin
            assert_reset_level_R4: assert (bank0_p == 2'b00 && bank0_n == 2'b11 &&
                                           !bank1_p && bank1_n && !bank2_p && bank2_n)
                else $error("outputs not at reset levels");
        end
    end

    assert_complement_R5: assert property (@(posedge src_clk) disable iff (div_rst)
        (bank0_n == ~bank0_p) && (bank1_n == !bank1_p) && (bank2_n == !bank2_p))
        else $error("complement mismatch");

    assert_pairs_equal_R9: assert property (@(posedge src_clk) disable iff (div_rst)
        bank0_p[0] == bank0_p[1])
        else $error("bank 0 pairs differ");

    assert_common_start_R6: assert property (@(posedge src_clk) disable iff (div_rst)
        $past(div_rst) |=> (bank0_p == 2'b11 && bank1_p && bank2_p))
        else $error("banks did not start together");

endmodule

bind clk_bank_div clk_bank_div_chk u_chk (
    .src_clk (src_clk),
    .div_rst (div_rst),
    .bank0_p (bank0_p),
    .bank0_n (bank0_n),
    .bank1_p (bank1_p),
    .bank1_n (bank1_n),
    .bank2_p (bank2_p),
    .bank2_n (bank2_n)
);

// File: tb/sim_clk_bank_div.sv
`timescale 1ns/1ps
module sim_clk_bank_div;

    logic       div_rst = 1'b1;
    logic       vco_clk = 1'b0;
    logic       osc_clk = 1'b0;
    logic       tst_clk = 1'b0;
    logic       pll_en  = 1'b1;
    logic       ref_sel = 1'b1;
    logic [1:0] bank0_code = 2'b00;
    logic [1:0] bank1_code = 2'b10;
    logic [1:0] bank2_code = 2'b10;
    logic [1:0] bank0_p, bank0_n;
    logic       bank1_p, bank1_n, bank2_p, bank2_n;

    int  n_tests = 0;
    int  n_fail  = 0;
    int  cyc     = 0;
    bit  done    = 1'b0;
    int  bsel    = 0;
    logic mon;

    always #4  vco_clk = ~vco_clk;   // 125 MHz, 8 ns
    always #10 osc_clk = ~osc_clk;   // 20 ns
    always #14 tst_clk = ~tst_clk;   // 28 ns

    clk_bank_div u0 (
        .div_rst    (div_rst),
        .vco_clk    (vco_clk),
        .osc_clk    (osc_clk),
        .tst_clk    (tst_clk),
        .pll_en     (pll_en),
        .ref_sel    (ref_sel),
        .bank0_code (bank0_code),
        .bank1_code (bank1_code),
        .bank2_code (bank2_code),
        .bank0_p    (bank0_p),
        .bank0_n    (bank0_n),
        .bank1_p    (bank1_p),
        .bank1_n    (bank1_n),
        .bank2_p    (bank2_p),
        .bank2_n    (bank2_n)
    );

    always_comb begin
        case (bsel)
            0:       mon = bank0_p[0];
            1:       mon = bank1_p;
            default: mon = bank2_p;
        endcase
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int ratio_of(input int code);
        case (code)
            0:       return 2;
            1:       return 3;
            2:       return 4;
            default: return 6;
        endcase
    endfunction

    // Level after the k-th source edge following reset release (even ratios).
    function automatic int lvl_after(input int k, input int d, input int n);
        if (k <= d) return ((k - 1) < d / 2) ? 1 : 0;
        return (((k - 1 - d) % n) < n / 2) ? 1 : 0;
    endfunction

    task automatic measure(output int per, output int hi);
        time t0, t1, t2;
        @(posedge mon); t0 = $time;
        @(negedge mon); t1 = $time;
        @(posedge mon); t2 = $time;
        per = int'(t2 - t0);
        hi  = int'(t1 - t0);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge vco_clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
            finish_run();
        end
    end

    initial begin
        int per, hi, tsrc, n;
        time t0, t1, t2, t3, t4;

        // Reset state (R4, R5)
        #30;
        check(bank0_p == 2'b00 && !bank1_p && !bank2_p, "R4 reset true low",
              int'({bank0_p, bank1_p, bank2_p}), 0);
        check(bank0_n == 2'b11 && bank1_n && bank2_n, "R4 R5 reset complement high",
              int'({bank0_n, bank1_n, bank2_n}), 15);

        // R6/R7: common start, default first period, then code 11 (divide by 6)
        pll_en = 1'b1;
        bank0_code = 2'b11; bank1_code = 2'b11; bank2_code = 2'b11;
        @(negedge vco_clk); div_rst = 1'b0;
        for (int k = 1; k <= 8; k++) begin
            @(posedge vco_clk); #1;
            check(int'(bank0_p[0]) == lvl_after(k, 2, 6), "R6 R7 bank0 start",
                  int'(bank0_p[0]), lvl_after(k, 2, 6));
            check(int'(bank1_p) == lvl_after(k, 4, 6) && int'(bank2_p) == lvl_after(k, 4, 6),
                  "R6 R7 bank1/2 start", int'({bank1_p, bank2_p}), 3 * lvl_after(k, 4, 6));
        end

        // R8: code change mid-period on bank 1
        bsel = 1;
        @(posedge mon);
        @(posedge mon); t0 = $time;
        #10 bank1_code = 2'b00;
        @(negedge mon); t1 = $time;
        @(posedge mon); t2 = $time;
        @(negedge mon); t3 = $time;
        @(posedge mon); t4 = $time;
        check(t1 - t0 == 24, "R8 old high kept", int'(t1 - t0), 24);
        check(t2 - t0 == 48, "R8 old period kept", int'(t2 - t0), 48);
        check(t3 - t2 == 8,  "R8 new high", int'(t3 - t2), 8);
        check(t4 - t2 == 16, "R8 new period", int'(t4 - t2), 16);

        // R4: asynchronous reset mid-run, while an output is high
        @(posedge bank1_p); #1;
        div_rst = 1'b1; #1;
        check(bank0_p == 2'b00 && !bank1_p && !bank2_p, "R4 async true low",
              int'({bank0_p, bank1_p, bank2_p}), 0);
        check(bank0_n == 2'b11 && bank1_n && bank2_n, "R4 async complement high",
              int'({bank0_n, bank1_n, bank2_n}), 15);
        #100;
        check(bank0_p == 2'b00 && !bank1_p && !bank2_p, "R4 held",
              int'({bank0_p, bank1_p, bank2_p}), 0);

        // Sweep: every source mode x every code x every bank (R1, R2, R3, R5, R9)
        for (int m = 0; m < 3; m++) begin
            for (int code = 0; code < 4; code++) begin
                div_rst = 1'b1;
                bsel = 0;
                pll_en  = (m == 0);
                ref_sel = (m == 1);
                tsrc = (m == 0) ? 8 : ((m == 1) ? 20 : 28);
                bank0_code = 2'(code); bank1_code = 2'(code); bank2_code = 2'(code);
                n = ratio_of(code);
                #60;
                div_rst = 1'b0;
                for (int b = 0; b < 3; b++) begin
                    bsel = b;
                    @(posedge mon);
                    @(posedge mon);
                    measure(per, hi);
                    check(per == n * tsrc, "R1 R3 period", per, n * tsrc);
                    check(2 * hi == n * tsrc, "R2 high half", hi, n * tsrc / 2);
                end
                #3;
                check(bank0_p[0] == bank0_p[1] && bank0_n[0] == bank0_n[1], "R9 pairs equal",
                      int'(bank0_p), int'({2{bank0_p[0]}}));
                check(bank0_n == ~bank0_p && bank1_n == !bank1_p && bank2_n == !bank2_p,
                      "R5 complement", int'({bank0_n, bank1_n, bank2_n}),
                      int'({~bank0_p, !bank1_p, !bank2_p}));
            end
        end

        finish_run();
    end

endmodule